// File: doc/BRIEF.md
# Power domain command sequencer

This block switches a bank of power domains on and off under software control. Software selects domains by loading a bit mask into a power-up mask register or a power-down mask register. It then writes a guarded three-byte sequence to a single command register. The first byte is a restart byte, followed by a low/high byte pair that picks the direction. A parser state machine checks each byte as it arrives. Only a complete and valid sequence reaches the domains. Any stray byte aborts the attempt and is recorded as a failure.

Each domain power switch is modelled by a settle counter. A domain's reported state flips only after a fixed number of cycles has passed. Software polls the current-state register until the targeted bits match the request. It can also wait for the sequence-done interrupt. Interrupt status bits are sticky and write-one-to-clear. A mask register selects which of them drive the interrupt output. Register writes take effect in one cycle. Read data is registered.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset all domains read as off, both domain masks, the interrupt mask and the interrupt status are zero, irq is low and rdata is zero.
- R2: The power-up mask (0x0C) and power-down mask (0x10) read back the low NUM_DOM bits written to them. The interrupt mask (0x48) reads back its low 9 bits. The command register (0x44) and any unused offset read as zero. rdata shows the addressed value in the cycle after rd_en is high, and is zero in the cycle after rd_en is low.
- R3: Writing 0xFF, 0x05, 0x50 to 0x44 starts power-up of every domain whose bit is set in the power-up mask. Each such domain's bit in dom_pwr, and in the current-state register 0x80, goes to 1 exactly SETTLE_CYC clock edges after the edge that accepted the 0x50 byte.
- R4: Writing 0xFF, 0x0A, 0xA0 to 0x44 powers down, with the same timing, every domain set in the power-down mask.
- R5: Domains whose mask bit is 0 keep their state. A domain already in the requested state does not change.
- R6: A byte that does not continue a valid sequence sets interrupt status bit 2 and returns the parser to idle. While idle, every byte other than 0xFF is such an error.
- R7: 0xFF restarts the parser at any point, with no error. For example, 0xFF 0x05 0xFF 0x05 0x50 is a valid power-up sequence.
- R8: Interrupt status bit 0 (sequence done) is set one edge after the last targeted domain flips. If no domain needs to change, it is set on the edge after the command was accepted.
- R9: A command completed while an earlier one is still in progress is rejected. It sets interrupt status bit 3 and changes no domain. The earlier command still completes and sets bit 0.
- R10: Writing 1s to 0x8C clears the matching status bits. If a status bit is set in the same cycle it is being cleared, the set wins. Status bits 1 and 4 to 8 always read zero.
- R11: irq is high one cycle after any status bit whose interrupt-mask bit is 0 is set. A mask bit of 1 blocks that status bit.
- R12: Bit 0 of the event register 0x88 reads 1 while any domain is settling and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, OR of unmasked status bits |
| dom_pwr | output | NUM_DOM | Current on/off state of each domain |

## Verification
The sequence-done bit can be set by the settle logic in the same cycle that software writes 1 to clear it. The bench provokes this by counting cycles from the edge that accepts the final command byte. It then places a write-one-to-clear of bit 0 on exactly the edge where completion is flagged. The status read-back must still show bit 0 set, and irq must be high. A second collision is also tested: a new command completes while the first is still settling. For this case the bench checks that the rejection bit and the done bit both appear, and that the final domain state is the one the first command produced.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  // register offsets
  localparam logic [7:0] OFS_UP_MASK   = 8'h0C;
  localparam logic [7:0] OFS_DN_MASK   = 8'h10;
  localparam logic [7:0] OFS_CMD       = 8'h44;
  localparam logic [7:0] OFS_INT_MASK  = 8'h48;
  localparam logic [7:0] OFS_CUR_STATE = 8'h80;
  localparam logic [7:0] OFS_EVENT     = 8'h88;
  localparam logic [7:0] OFS_INT_STS   = 8'h8C;

  // command bytes
  localparam logic [7:0] BYTE_RESTART = 8'hFF;
  localparam logic [7:0] BYTE_UP_LO   = 8'h05;
  localparam logic [7:0] BYTE_UP_HI   = 8'h50;
  localparam logic [7:0] BYTE_DN_LO   = 8'h0A;
  localparam logic [7:0] BYTE_DN_HI   = 8'hA0;

  // interrupt status layout
  localparam int STS_W        = 9;
  localparam int STS_DONE     = 0;
  localparam int STS_SEQ_ERR  = 2;
  localparam int STS_BUSY_REJ = 3;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ARMED = 2'd1,
    PS_UP_LO = 2'd2,
    PS_DN_LO = 2'd3
  } parse_st_t;
endpackage

// File: rtl/pwr_cmd_parser.sv
module pwr_cmd_parser
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       fire_up,
  output logic       fire_dn,
  output logic       seq_err
);
  parse_st_t st_q, st_d;

  always_comb begin
    st_d    = st_q;
    fire_up = 1'b0;
    fire_dn = 1'b0;
    seq_err = 1'b0;
    if (byte_vld) begin
      if (byte_in == BYTE_RESTART) begin
        st_d = PS_ARMED;
      end else begin
        st_d = PS_IDLE;
        unique case (st_q)
          PS_ARMED: begin
            if (byte_in == BYTE_UP_LO)      st_d = PS_UP_LO;
            else if (byte_in == BYTE_DN_LO) st_d = PS_DN_LO;
            else                            seq_err = 1'b1;
          end
          PS_UP_LO: begin
            if (byte_in == BYTE_UP_HI) fire_up = 1'b1;
            else                       seq_err = 1'b1;
          end
          PS_DN_LO: begin
            if (byte_in == BYTE_DN_HI) fire_dn = 1'b1;
            else                       seq_err = 1'b1;
          end
          default: seq_err = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/pwr_dom_switch.sv
module pwr_dom_switch #(
  parameter int SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic target,
  output logic pwr_on,
  output logic settling
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tgt_q  <= 1'b0;
      pwr_on <= 1'b0;
    end else if (start) begin
      cnt_q <= CNT_W'(SETTLE_CYC);
      tgt_q <= target;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) pwr_on <= tgt_q;
    end
  end

  assign settling = (cnt_q != '0);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_DOM    = 8,
  parameter int SETTLE_CYC = 64,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [NUM_DOM-1:0] dom_pwr
);
  localparam logic [ADDR_W-1:0] A_UP  = ADDR_W'(OFS_UP_MASK);
  localparam logic [ADDR_W-1:0] A_DN  = ADDR_W'(OFS_DN_MASK);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_IM  = ADDR_W'(OFS_INT_MASK);
  localparam logic [ADDR_W-1:0] A_CUR = ADDR_W'(OFS_CUR_STATE);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(OFS_EVENT);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_INT_STS);

  logic [NUM_DOM-1:0] up_mask, dn_mask;
  logic [STS_W-1:0]   int_msk, int_sts;
  logic               fire_up, fire_dn, seq_err;
  logic               busy_any, pending, accept, reject, done_set;
  logic [NUM_DOM-1:0] sel_mask, dom_start, dom_settling;
  logic [STS_W-1:0]   sts_set, sts_clr;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:STS_W];

  pwr_cmd_parser u_parser (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (wr_en && addr == A_CMD),
    .byte_in  (wdata[7:0]),
    .fire_up  (fire_up),
    .fire_dn  (fire_dn),
    .seq_err  (seq_err)
  );

  // command acceptance
  assign busy_any = |dom_settling;
  assign accept   = (fire_up || fire_dn) && !busy_any && !pending;
  assign reject   = (fire_up || fire_dn) && !accept;
  assign done_set = pending && !busy_any;
  assign sel_mask = fire_up ? up_mask : dn_mask;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign dom_start[g] = accept && sel_mask[g] && (dom_pwr[g] != fire_up);
    pwr_dom_switch #(.SETTLE_CYC(SETTLE_CYC)) u_sw (
      .clk      (clk),
      .rst      (rst),
      .start    (dom_start[g]),
      .target   (fire_up),
      .pwr_on   (dom_pwr[g]),
      .settling (dom_settling[g])
    );
  end

  // status set / clear
  always_comb begin
    sts_set               = '0;
    sts_set[STS_DONE]     = done_set;
    sts_set[STS_SEQ_ERR]  = seq_err;
    sts_set[STS_BUSY_REJ] = reject;
    sts_clr = (wr_en && addr == A_STS) ? wdata[STS_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_mask <= '0;
      dn_mask <= '0;
      int_msk <= '0;
      int_sts <= '0;
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_en && addr == A_UP) up_mask <= wdata[NUM_DOM-1:0];
      if (wr_en && addr == A_DN) dn_mask <= wdata[NUM_DOM-1:0];
      if (wr_en && addr == A_IM) int_msk <= wdata[STS_W-1:0];
      int_sts <= (int_sts & ~sts_clr) | sts_set;
      if (accept)        pending <= 1'b1;
      else if (done_set) pending <= 1'b0;
      irq <= |(int_sts & ~int_msk);
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (addr)
      A_UP:  rd_mux[NUM_DOM-1:0] = up_mask;
      A_DN:  rd_mux[NUM_DOM-1:0] = dn_mask;
      A_IM:  rd_mux[STS_W-1:0]   = int_msk;
      A_CUR: rd_mux[NUM_DOM-1:0] = dom_pwr;
      A_EVT: rd_mux[0]           = busy_any;
      A_STS: rd_mux[STS_W-1:0]   = int_sts;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
    else            rdata <= '0;
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int NUM_DOM = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq,
  input logic [NUM_DOM-1:0] dom_pwr,
  input logic               busy_any,
  input logic [8:0]         int_sts,
  input logic [8:0]         int_msk
);
  logic rst_q;
  logic unused_w;
  assign unused_w = ^{wdata[DATA_W-1:3], wdata[1:0]};

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_state_r1: assert (dom_pwr == '0 && !irq && rdata == '0 && int_sts == '0)
        else $error("R1 reset state wrong");
    end
  end

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rdata == '0);

  p_dom_change_r5: assert property (@(posedge clk) disable iff (rst)
    (dom_pwr != $past(dom_pwr)) |-> $past(busy_any));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(int_sts[0]) |-> !busy_any);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(int_sts[2]) |-> $past(wr_en && addr == ADDR_W'(8'h8C) && wdata[2]));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(int_sts & ~int_msk)));
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq      (irq),
  .dom_pwr  (dom_pwr),
  .busy_any (busy_any),
  .int_sts  (int_sts),
  .int_msk  (int_msk)
);

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;
  localparam int N  = 10;
  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [ND-1:0] dom_pwr;

  int checks = 0, fails = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.NUM_DOM(ND), .SETTLE_CYC(N), .ADDR_W(8), .DATA_W(32)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .dom_pwr(dom_pwr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected read got %h exp none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic seq_up();
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
  endtask

  task automatic seq_dn();
    wr(8'h44, 32'hFF); wr(8'h44, 32'h0A); wr(8'h44, 32'hA0);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dom_pwr", 32'(dom_pwr), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(8'h80, 32'h0, "R1 cur state");
    rd(8'h8C, 32'h0, "R1 int status");
    rd(8'h0C, 32'h0, "R1 up mask");

    // R2 register access
    wr(8'h0C, 32'h0000_01A5); rd(8'h0C, 32'hA5, "R2 up mask");
    wr(8'h10, 32'h0000_003C); rd(8'h10, 32'h3C, "R2 dn mask");
    wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, 32'h1FF, "R2 int mask");
    rd(8'h44, 32'h0, "R2 cmd reads zero");
    rd(8'h20, 32'h0, "R2 unused offset");
    @(negedge clk);
    chk("R2 rdata idle", rdata, 32'h0);

    // R3 power-up timing
    wr(8'h0C, 32'hA5);
    seq_up();
    repeat (N - 1) @(negedge clk);
    chk("R3 before settle", 32'(dom_pwr), 32'h00);
    @(negedge clk);
    chk("R3 after settle", 32'(dom_pwr), 32'hA5);
    rd(8'h8C, 32'h0, "R8 done not yet");
    rd(8'h8C, 32'h1, "R8 done set");
    rd(8'h80, 32'hA5, "R3 cur state reg");
    chk("R11 irq masked", 32'(irq), 32'h0);
    wr(8'h48, 32'h1FE);
    @(negedge clk);
    chk("R11 irq unmasked", 32'(irq), 32'h1);
    wr(8'h8C, 32'h1);
    @(negedge clk);
    chk("R11 irq after clear", 32'(irq), 32'h0);
    rd(8'h8C, 32'h0, "R10 w1c cleared");

    // R4 / R5 power-down, partly already off
    seq_dn();
    rd(8'h88, 32'h1, "R12 busy while settling");
    repeat (N + 3) @(negedge clk);
    chk("R4 R5 after power-down", 32'(dom_pwr), 32'h81);
    rd(8'h88, 32'h0, "R12 idle");
    rd(8'h8C, 32'h1, "R4 done");
    wr(8'h8C, 32'h1FF);

    // R8 no-change command completes next edge
    wr(8'h0C, 32'h01);
    seq_up();
    rd(8'h8C, 32'h0, "R8 no-change first edge");
    rd(8'h8C, 32'h1, "R8 no-change done");
    chk("R5 already on", 32'(dom_pwr), 32'h81);
    wr(8'h8C, 32'h1FF);

    // R6 broken sequences
    wr(8'h0C, 32'h02);
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h33);
    wr(8'h44, 32'h05); wr(8'h44, 32'h50);
    repeat (N + 3) @(negedge clk);
    chk("R6 no change", 32'(dom_pwr), 32'h81);
    rd(8'h8C, 32'h4, "R6 error bit");
    wr(8'h8C, 32'h1FF);

    // R7 restart mid-sequence
    wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'hFF);
    wr(8'h44, 32'h05); wr(8'h44, 32'h50);
    repeat (N + 3) @(negedge clk);
    chk("R7 restart valid", 32'(dom_pwr), 32'h83);
    rd(8'h8C, 32'h1, "R7 no error");
    wr(8'h8C, 32'h1FF);

    // R9 command while busy
    wr(8'h0C, 32'h40); wr(8'h10, 32'h40);
    seq_up();
    seq_dn();
    repeat (N + 3) @(negedge clk);
    chk("R9 first command wins", 32'(dom_pwr), 32'hC3);
    rd(8'h8C, 32'h9, "R9 reject and done");
    wr(8'h8C, 32'h1FF);

    // R10 set/clear collision on done
    wr(8'h0C, 32'h10);
    seq_up();
    repeat (N) @(negedge clk);
    wr(8'h8C, 32'h1);
    rd(8'h8C, 32'h1, "R10 set wins over clear");
    chk("R11 irq on done", 32'(irq), 32'h1);
    chk("R3 second up", 32'(dom_pwr), 32'hD3);
    wr(8'h8C, 32'h1);
    rd(8'h8C, 32'h0, "R10 later clear");

    finish_run();
  end
endmodule